// File: doc/BRIEF.md
# Laplacian Edge Filter Engine

The block runs a fixed 3x3 Laplacian edge-detection filter over a square grayscale image held in an external memory with synchronous reads. A one-cycle start pulse begins a pass. The engine then computes every output pixel in turn. For each pixel it issues the reads for the pixel and its eight neighbours through an address/data port and adds up the weighted samples. It clamps the sum to seven bits and offers the result as one beat on an AXI4-Stream master.

The centre weight is +8 and each of the eight neighbours weighs -1. Positions outside the image are treated as zero, so the output image has the same size as the input. Results leave in row-major order starting at the top-left pixel, and the last pixel carries tlast. One cycle after that last beat is accepted, a done pulse tells the controller that the pass has finished. The side edge is a power of two, 2^IMG_LOG2, which gives 256 by 256 and a 16-bit address by default.

Top module: `lap_conv_engine`

## Requirements
- R1: When reset is released, and for as long as no start pulse arrives, m_tvalid and done stay low.
- R2: Each interior pixel's result is 8 times the centre sample minus the sum of its eight neighbours. Each sample is taken from mem_data in the cycle after its address was driven on mem_addr (address = row * width + column, with the row in the upper half of the address).
- R3: Any neighbour that lies outside the image contributes zero to the sum, and the output image has as many pixels as the input.
- R4: A sum below zero is output as 0.
- R5: A sum above 127 is output as 127, and bit 7 of m_tdata is always 0.
- R6: Exactly width*width beats are sent per pass, in row-major order from the top-left pixel, before done is raised.
- R7: m_tlast is high on the final beat of the pass and low on every other beat.
- R8: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata, m_tlast and mem_addr all hold their values.
- R9: done is high for exactly one cycle, the cycle after the final beat is accepted, and never in the same cycle as m_tvalid.
- R10: A start pulse that arrives while a pass is running has no effect on the outputs or on the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a pass when the engine is idle |
| done | output | 1 | One-cycle pulse after the final output beat |
| mem_addr | output | 2*IMG_LOG2 | Read address into the image memory |
| mem_data | input | PIX_W | Pixel read back one cycle after mem_addr |
| m_tdata | output | OUT_W | Filtered pixel, zero-extended |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tlast | output | 1 | Marks the last pixel of the image |

## Verification
Most internal faults in this engine show up on the stream within one pixel period, which is eleven cycles. A tap counter that slips, or a data-to-address alignment that is off by one cycle, corrupts the very first pixel. A wrong border test only shows up at the image edges, so every edge pixel and every corner pixel is compared against an independent model. A pixel counter that wraps or skips moves tlast or the done pulse away from beat width*width. The bench uses several patterns chosen to drive the sum into both saturation limits. It also stalls the stream repeatedly, which shows any loss of the held beat or any movement of the address during a stall.

// File: rtl/lap_pkg.sv
// Shared definitions for the Laplacian filter engine.
// Assumes a 3x3 kernel whose centre weight is a power of two.
package lap_pkg;
    // Sequencer phases of one pass
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAPS,
        ST_DRAIN,
        ST_OUT,
        ST_DONE
    } lap_state_t;

    // Centre weight 8 is applied as a left shift by this amount
    localparam int CENTRE_SHIFT = 3;
    // Last index of the tap row/column counters (taps 0..2)
    localparam logic [1:0] TAP_END = 2'd2;
endpackage

// File: rtl/lap_ctrl.sv
// Pass sequencer: per pixel, issue nine taps, wait one cycle for the
// last read to return, then present the result until it is accepted.
// Assumes tap_last and pix_last come from the scan counters.
module lap_ctrl
    import lap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tap_last,
    input  logic pix_last,
    input  logic m_tready,
    output logic clear,
    output logic tap_step,
    output logic pix_step,
    output logic out_valid,
    output logic done
);
    lap_state_t state, state_nx;

    assign clear     = (state == ST_IDLE) && start;
    assign tap_step  = (state == ST_TAPS);
    assign out_valid = (state == ST_OUT);
    assign pix_step  = out_valid && m_tready;
    assign done      = (state == ST_DONE);

    // Next-phase decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_TAPS;
            ST_TAPS:  if (tap_last) state_nx = ST_DRAIN;
            ST_DRAIN: state_nx = ST_OUT;
            ST_OUT:   if (m_tready) state_nx = pix_last ? ST_DONE : ST_TAPS;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Phase register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/lap_scan.sv
// Pixel and tap position counters plus neighbour address generation.
// Assumes a square image of 2^IMG_LOG2 per side; tap_step and pix_step
// are never high together. Out-of-image taps are flagged, not skipped.
module lap_scan
    import lap_pkg::*;
#(
    parameter int IMG_LOG2 = 8,
    localparam int ADDR_W = 2 * IMG_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tap_step,
    input  logic              pix_step,
    output logic [ADDR_W-1:0] addr,
    output logic              tap_inb,
    output logic              tap_centre,
    output logic              tap_first,
    output logic              tap_last,
    output logic              pix_last
);
    localparam logic [IMG_LOG2-1:0] EDGE = '1;
    localparam logic [IMG_LOG2-1:0] ONE  = IMG_LOG2'(1);

    logic [IMG_LOG2-1:0] row, col, nrow, ncol;
    logic [1:0]          trow, tcol;

    // Neighbour coordinates for the current tap (wrap is masked by tap_inb)
    always_comb begin
        unique case (trow)
            2'd0:    nrow = row - ONE;
            2'd1:    nrow = row;
            default: nrow = row + ONE;
        endcase
        unique case (tcol)
            2'd0:    ncol = col - ONE;
            2'd1:    ncol = col;
            default: ncol = col + ONE;
        endcase
    end

    // Tap flags and address
    always_comb begin
        tap_inb = !((trow == 2'd0) && (row == '0)) &&
                  !((trow == TAP_END) && (row == EDGE)) &&
                  !((tcol == 2'd0) && (col == '0)) &&
                  !((tcol == TAP_END) && (col == EDGE));
        tap_centre = (trow == 2'd1) && (tcol == 2'd1);
        tap_first  = (trow == 2'd0) && (tcol == 2'd0);
        tap_last   = (trow == TAP_END) && (tcol == TAP_END);
        pix_last   = (row == EDGE) && (col == EDGE);
        addr       = {nrow, ncol};
    end

    // Tap counter walks the 3x3 window column first, row second
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            trow <= '0;
            tcol <= '0;
        end else if (tap_step) begin
            if (tcol == TAP_END) begin
                tcol <= '0;
                trow <= (trow == TAP_END) ? 2'd0 : trow + 2'd1;
            end else begin
                tcol <= tcol + 2'd1;
            end
        end
    end

    // Pixel counter advances in raster order on each accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            row <= '0;
            col <= '0;
        end else if (pix_step) begin
            if (col == EDGE) begin
                col <= '0;
                row <= row + ONE;
            end else begin
                col <= col + ONE;
            end
        end
    end
endmodule

// File: rtl/lap_mac.sv
// Weighted accumulator aligned to a one-cycle-latency memory read.
// Assumes tap flags describe the address issued in the same cycle;
// they are delayed one cycle to meet the returning data.
module lap_mac
    import lap_pkg::*;
#(
    parameter int PIX_W = 7,
    localparam int ACC_W = PIX_W + 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue,
    input  logic                    inb,
    input  logic                    centre,
    input  logic                    first,
    input  logic [PIX_W-1:0]        rd_data,
    output logic signed [ACC_W-1:0] acc
);
    logic                    issue_q, inb_q, centre_q, first_q;
    logic signed [ACC_W-1:0] ext, contrib, base;

    // Delay tap flags to the cycle in which the read data returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q  <= 1'b0;
            inb_q    <= 1'b0;
            centre_q <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            issue_q  <= issue;
            inb_q    <= issue && inb;
            centre_q <= centre;
            first_q  <= first;
        end
    end

    // Signed contribution of the returning sample
    always_comb begin
        ext     = signed'({{(ACC_W - PIX_W){1'b0}}, rd_data});
        contrib = centre_q ? (ext <<< CENTRE_SHIFT) : -ext;
        base    = first_q ? '0 : acc;
    end

    // Accumulate; the first tap of a window restarts the sum
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (issue_q) acc <= base + (inb_q ? contrib : '0);
    end
endmodule

// File: rtl/lap_conv_engine.sv
// Top of the Laplacian edge filter: sequencer, scan counters,
// accumulator, and the saturating AXI4-Stream output.
// Assumes memory data returns one cycle after the address.
module lap_conv_engine #(
    parameter int IMG_LOG2 = 8,
    parameter int PIX_W    = 7,
    parameter int OUT_W    = 8,
    localparam int ADDR_W  = 2 * IMG_LOG2,
    localparam int ACC_W   = PIX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [PIX_W-1:0]  mem_data,
    output logic [OUT_W-1:0]  m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast
);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

    logic clear, tap_step, pix_step, out_valid;
    logic tap_inb, tap_centre, tap_first, tap_last, pix_last;
    logic signed [ACC_W-1:0] acc;
    logic [PIX_W-1:0]        sat;

    lap_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tap_last  (tap_last),
        .pix_last  (pix_last),
        .m_tready  (m_tready),
        .clear     (clear),
        .tap_step  (tap_step),
        .pix_step  (pix_step),
        .out_valid (out_valid),
        .done      (done)
    );

    lap_scan #(.IMG_LOG2(IMG_LOG2)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .tap_step   (tap_step),
        .pix_step   (pix_step),
        .addr       (mem_addr),
        .tap_inb    (tap_inb),
        .tap_centre (tap_centre),
        .tap_first  (tap_first),
        .tap_last   (tap_last),
        .pix_last   (pix_last)
    );

    lap_mac #(.PIX_W(PIX_W)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (tap_step),
        .inb     (tap_inb),
        .centre  (tap_centre),
        .first   (tap_first),
        .rd_data (mem_data),
        .acc     (acc)
    );

    // Saturate the signed sum into the unsigned pixel range
    always_comb begin
        if (acc < 0)         sat = '0;
        else if (acc > MAXV) sat = '1;
        else                 sat = acc[PIX_W-1:0];
    end

    // Stream outputs; the sum is stable for the whole OUT phase
    always_comb begin
        m_tvalid = out_valid;
        m_tlast  = out_valid && pix_last;
        m_tdata  = out_valid ? {{(OUT_W - PIX_W){1'b0}}, sat} : '0;
    end
endmodule

// File: rtl/lap_conv_sva.sv
// Port-level properties of the Laplacian filter engine, bound to the top.
module lap_conv_sva #(
    parameter int ADDR_W = 16,
    parameter int OUT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [OUT_W-1:0]  m_tdata,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic              m_tlast
);
    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!m_tvalid && !done));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
                                     $stable(m_tlast) && $stable(mem_addr)));

    // R5
    msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !m_tdata[OUT_W-1]);

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !m_tvalid);
endmodule

bind lap_conv_engine lap_conv_sva #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .mem_addr (mem_addr),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast)
);

// File: tb/lap_conv_engine_bench.sv
module lap_conv_engine_bench;
    localparam int LOG2  = 3;
    localparam int W     = 1 << LOG2;
    localparam int N     = W * W;
    localparam int PIX_W = 7;
    localparam int OUT_W = 8;
    localparam int AW    = 2 * LOG2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             done;
    logic [AW-1:0]    mem_addr;
    logic [PIX_W-1:0] mem_data = '0;
    logic [OUT_W-1:0] m_tdata;
    logic             m_tvalid;
    logic             m_tready = 1'b1;
    logic             m_tlast;

    logic [PIX_W-1:0] mem [N];
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    lap_conv_engine #(.IMG_LOG2(LOG2), .PIX_W(PIX_W), .OUT_W(OUT_W)) u_lap_conv_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
    );

    // Memory model with one cycle of read latency
    always @(posedge clk) mem_data <= mem[mem_addr];

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int px(int r, int c);
        if (r < 0 || r >= W || c < 0 || c >= W) return 0;
        return int'(mem[r * W + c]);
    endfunction

    function automatic int raw_sum(int r, int c);
        int s = 8 * px(r, c);
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (dr != 0 || dc != 0) s -= px(r + dr, c + dc);
        return s;
    endfunction

    function automatic int pat_val(int pat, int r, int c);
        case (pat)
            0: return (r * 13 + c * 7 + r * c) % 128;
            1: return 127;
            2: return ((r + c) % 2 == 0) ? 127 : 0;
            3: return (r == 3 && c == 4) ? 100 : ((r == 0 && c == 0) ? 9 : 0);
            default: return c * 3;
        endcase
    endfunction

    task automatic fill(int pat);
        for (int r = 0; r < W; r++)
            for (int c = 0; c < W; c++)
                mem[r * W + c] = PIX_W'(pat_val(pat, r, c));
    endtask

    // One pass: checks every beat, stalls, tlast, done timing
    task automatic run_frame(string name, int pat, bit stall, bit restart);
        int beats = 0, dones = 0, k = 0, s, e, r, c;
        bit prev_stall = 0;
        logic [OUT_W-1:0] pd = '0;
        logic [AW-1:0] pa = '0;
        string req;
        fill(pat);
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        while (dones == 0 && k < 5000) begin
            start = 1'b0;
            if (prev_stall) begin
                // R8 held beat and frozen address
                check("R8", int'(m_tvalid), 1, {name, " valid held"});
                check("R8", int'(m_tdata), int'(pd), {name, " data held"});
                check("R8", int'(mem_addr), int'(pa), {name, " addr frozen"});
            end
            m_tready = stall ? ((k % 3) != 1) : 1'b1;
            if (m_tvalid) begin
                if (m_tready) begin
                    r = beats / W; c = beats % W;  // R6 raster order
                    s = raw_sum(r, c);
                    e = (s < 0) ? 0 : ((s > 127) ? 127 : s);
                    if (r == 0 || c == 0 || r == W - 1 || c == W - 1) req = "R3";
                    else if (s < 0) req = "R4";
                    else if (s > 127) req = "R5";
                    else req = "R2";
                    check(req, int'(m_tdata), e, $sformatf("%s pixel %0d", name, beats));
                    check("R7", int'(m_tlast), int'(beats == N - 1), $sformatf("%s tlast %0d", name, beats));
                    beats++;
                    if (restart && beats == 5) start = 1'b1;  // R10 start while busy
                end
                prev_stall = !m_tready;
                pd = m_tdata; pa = mem_addr;
            end else prev_stall = 0;
            if (done) begin
                check("R6", beats, N, {name, " beats before done"});
                check("R9", int'(m_tvalid), 0, {name, " no valid with done"});
                dones++;
            end
            @(negedge clk);
            k++;
        end
        check("R9", dones, 1, {name, " done seen"});
        check("R9", int'(done), 0, {name, " done one cycle"});
        m_tready = 1'b1;
        // R10: no second pass started by the ignored pulse
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (m_tvalid || done) begin
                check("R10", 1, 0, {name, " activity after pass"});
                break;
            end
        end
        check("R10", int'(m_tvalid), 0, {name, " idle after pass"});
    endtask

    task automatic t_reset;
        int seen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(m_tvalid), 0, "tvalid after reset");
        check("R1", int'(done), 0, "done after reset");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (m_tvalid || done) seen++;
        end
        check("R1", seen, 0, "no output without start");
    endtask

    initial begin
        t_reset();
        run_frame("mixed", 0, 1'b0, 1'b0);
        run_frame("flat", 1, 1'b0, 1'b0);
        run_frame("checker", 2, 1'b0, 1'b0);
        run_frame("hot", 3, 1'b1, 1'b0);
        run_frame("ramp", 4, 1'b0, 1'b0);
        run_frame("mixed_stall_restart", 0, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule